// File: doc/BRIEF.md
# I2C Bus Busy Monitor and Condition Generator

This block watches the two lines of an I2C bus and keeps a flag that says whether the bus is occupied. A START condition on the lines (SDA falling while SCL is high) sets the flag. A STOP condition (SDA rising while SCL is high) clears it. Both lines pass through a two-stage synchronizer, and every judgement is made on the synchronized samples. The pads are open-drain, so the block pulls a line low by asserting an output enable and releases it by deasserting that enable.

Software commands conditions through a handful of write strobes. A write with the busy bit set and the command-inhibit bit clear requests a START, or a repeated START when the bus is already owned. A write with the busy bit clear requests a STOP. In master receive mode a STOP or repeated START request is parked until the receive-full flag is set and SCL is seen low. This keeps the bus from getting an extra clock cycle. A level-sensitive soft reset blocks command writes and forces the line monitor bits high. It does not clear the busy flag, and condition detection keeps running during it. A format-select strobe clears the busy flag. An SDA output bit lets software pull SDA low directly. A transmit-empty flag is set by soft reset in transmit mode.

Top module: `i2c_bus_guard`

## Requirements
- R1: Three clocks after SDA falls on the pins while SCL is high, `busy` reads 1.
- R2: Three clocks after SDA rises on the pins while SCL is high, `busy` reads 0.
- R3: A write (`ctl_we`=1, `ctl_busy`=1, `ctl_cmd`=0) in master transmit mode (`is_master`=1, `is_tx`=1), with both lines high and `busy`=0, asserts `sda_oe` right after the write edge. `scl_oe` follows exactly HOLD_CYC clocks later, and `busy` reads 1 by then.
- R4: A write with `ctl_busy`=0, `ctl_cmd`=0 in master transmit mode, while the block holds SCL low and SDA is low, drops `scl_oe` right after the write edge. `sda_oe` drops HOLD_CYC clocks later, and `busy` then reads 0.
- R5: A command write is ignored when `ctl_cmd`=1. A START write is also ignored unless `is_master`=1 and `is_tx`=1.
- R6: A pulse on `fmt_we` clears `busy` at the next clock edge.
- R7: While `srst`=1, `scl_mon` and `sda_mon` read 1 whatever the lines do, and `tx_empty` is set one clock after `srst`=1 with `is_tx`=1. Outside soft reset, `tx_wr` clears `tx_empty`.
- R8: Soft reset alone leaves `busy` at 1. A STOP on the lines during soft reset still clears it.
- R9: While `srst`=1, `ctl_we` and `sdo_we` have no effect on `scl_oe` or `sda_oe`.
- R10: In master receive mode (`is_tx`=0), a STOP request leaves `scl_oe` asserted until `rx_full`=1 with SCL low. `scl_oe` then drops at the next edge.
- R11: A START write while `busy`=1 and SCL is held by the block (repeated START, transmit mode) runs four steps, each HOLD_CYC clocks apart: release SDA, release SCL, pull SDA low, pull SCL low.
- R12: While a condition sequence runs, `arb_lost` pulses if SDA reads low with SCL high while the block is releasing SDA. No pulse comes from the block's own SDA release.
- R13: With `sdo_we` outside soft reset, `sdo_val`=0 asserts `sda_oe` at the next edge and `sdo_val`=1 releases it.
- R14: After reset: `busy`=0, `scl_oe`=0, `sda_oe`=0, `tx_empty`=1, `arb_lost`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | SCL pin level |
| sda_in | input | 1 | SDA pin level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| is_master | input | 1 | Mode: 1 master, 0 slave |
| is_tx | input | 1 | Mode: 1 transmit, 0 receive |
| rx_full | input | 1 | Receive register full flag |
| ctl_we | input | 1 | Write strobe for busy and command bits |
| ctl_busy | input | 1 | Busy bit value written |
| ctl_cmd | input | 1 | Command-inhibit bit value written |
| fmt_we | input | 1 | Format-select write of 1, clears busy |
| srst | input | 1 | Soft reset level |
| sdo_we | input | 1 | Write strobe for SDA output bit |
| sdo_val | input | 1 | SDA output bit value (0 pulls low) |
| tx_wr | input | 1 | Transmit data written, clears tx_empty |
| busy | output | 1 | Bus busy flag |
| scl_mon | output | 1 | Synchronized SCL level, 1 during soft reset |
| sda_mon | output | 1 | Synchronized SDA level, 1 during soft reset |
| tx_empty | output | 1 | Transmit data empty flag |
| arb_lost | output | 1 | One-clock arbitration-lost pulse |

## Verification
Line events reach `busy` three clocks after the pins change: two synchronizer stages, then the flag register. The bench therefore waits at least three clocks after moving a line before it samples `busy`. Command results on `scl_oe` and `sda_oe` appear just after the sampling edge, so the bench reads them 2 ns past that edge. It counts whole clocks between successive line-enable changes and compares each count with HOLD_CYC. Requests that are parked in master receive mode are checked twice: once after ten idle clocks, to show they are still held, and once just after the edge that samples `rx_full`.

// File: rtl/i2c_guard_pkg.sv
package i2c_guard_pkg;

    typedef enum logic [2:0] {
        G_IDLE,
        G_START,
        G_STOP,
        G_RS_SDA,
        G_RS_SCL
    } gen_st_e;

    typedef enum logic [1:0] {
        REQ_NONE,
        REQ_STOP,
        REQ_RS
    } req_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] dprev
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [WIDTH-1:0] pipe_q [STAGES+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i <= STAGES; i++) pipe_q[i] <= '1;
        end else begin
            pipe_q[0] <= din;
            for (int i = 1; i <= STAGES; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign dout  = pipe_q[STAGES-1];
    assign dprev = pipe_q[STAGES];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
    input  logic scl_s,
    input  logic sda_s,
    input  logic scl_p,
    input  logic sda_p,
    output logic start_det,
    output logic stop_det
);
    logic scl_hi;

    always_comb begin
        scl_hi    = scl_s & scl_p;
        start_det = scl_hi &  sda_p & ~sda_s;
        stop_det  = scl_hi & ~sda_p &  sda_s;
    end
endmodule

// File: rtl/i2c_bus_guard.sv
module i2c_bus_guard
    import i2c_guard_pkg::*;
#(
    parameter int HOLD_CYC    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_oe,
    output logic sda_oe,
    input  logic is_master,
    input  logic is_tx,
    input  logic rx_full,
    input  logic ctl_we,
    input  logic ctl_busy,
    input  logic ctl_cmd,
    input  logic fmt_we,
    input  logic srst,
    input  logic sdo_we,
    input  logic sdo_val,
    input  logic tx_wr,
    output logic busy,
    output logic scl_mon,
    output logic sda_mon,
    output logic tx_empty,
    output logic arb_lost
);
    localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(HOLD_CYC - 1);

    typedef struct packed {
        gen_st_e       st;
        logic [CW-1:0] cnt;
        logic          scl_low;
        logic          sda_low;
        req_e          pend;
        logic          busy;
        logic          sdao;
        logic          tx_empty;
        logic          arb;
        logic [1:0]    sda_pipe;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st: G_IDLE, cnt: '0, scl_low: 1'b0, sda_low: 1'b0, pend: REQ_NONE,
        busy: 1'b0, sdao: 1'b1, tx_empty: 1'b1, arb: 1'b0, sda_pipe: 2'b00
    };

    regs_t r_d, r_q;

    logic [1:0] line_s, line_p;
    logic       scl_s, sda_s, scl_p, sda_p;
    logic       start_det, stop_det;
    logic       gen_idle, sda_drive;

    i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_in, sda_in}),
        .dout  (line_s),
        .dprev (line_p)
    );

    assign scl_s = line_s[1];
    assign sda_s = line_s[0];
    assign scl_p = line_p[1];
    assign sda_p = line_p[0];

    i2c_cond_detect det_i (
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_p     (scl_p),
        .sda_p     (sda_p),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign gen_idle  = (r_q.st == G_IDLE);
    assign sda_drive = r_q.sda_low | ~r_q.sdao;

    logic wr_ok, start_req, rs_req, stop_req, rx_gate, stop_ok;
    logic go_start, go_stop, go_rs, cnt_end;

    always_comb begin
        r_d = r_q;

        // command decode: blocked while soft reset is held
        wr_ok     = ctl_we & ~srst & ~ctl_cmd & is_master;
        start_req = wr_ok & ctl_busy & ~r_q.busy & is_tx & scl_s & sda_s;
        rs_req    = wr_ok & ctl_busy & r_q.busy;
        stop_req  = wr_ok & ~ctl_busy;
        rx_gate   = ~srst & rx_full & ~scl_s;
        stop_ok   = r_q.scl_low & ~sda_s;
        cnt_end   = (r_q.cnt == CNT_LAST);

        go_start = gen_idle & start_req;
        go_stop  = gen_idle & stop_ok &
                   ((stop_req & is_tx) | ((r_q.pend == REQ_STOP) & rx_gate));
        go_rs    = gen_idle & r_q.scl_low &
                   ((rs_req & is_tx) | ((r_q.pend == REQ_RS) & rx_gate));

        // parked requests for master receive
        if (go_stop || go_rs) r_d.pend = REQ_NONE;
        if (srst)                      r_d.pend = REQ_NONE;
        else if (stop_req && !is_tx)   r_d.pend = REQ_STOP;
        else if (rs_req && !is_tx)     r_d.pend = REQ_RS;

        // condition sequencer
        unique case (r_q.st)
            G_IDLE: begin
                r_d.cnt = '0;
                if (go_start) begin
                    r_d.sda_low = 1'b1;
                    r_d.st      = G_START;
                end else if (go_stop) begin
                    r_d.scl_low = 1'b0;
                    r_d.st      = G_STOP;
                end else if (go_rs) begin
                    r_d.sda_low = 1'b0;
                    r_d.st      = G_RS_SDA;
                end
            end
            G_START: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (cnt_end) begin
                    r_d.scl_low = 1'b1;
                    r_d.st      = G_IDLE;
                end
            end
            G_STOP: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (cnt_end) begin
                    r_d.sda_low = 1'b0;
                    r_d.st      = G_IDLE;
                end
            end
            G_RS_SDA: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (cnt_end) begin
                    r_d.scl_low = 1'b0;
                    r_d.cnt     = '0;
                    r_d.st      = G_RS_SCL;
                end
            end
            G_RS_SCL: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (cnt_end) begin
                    r_d.sda_low = 1'b1;
                    r_d.cnt     = '0;
                    r_d.st      = G_START;
                end
            end
            default: r_d.st = G_IDLE;
        endcase

        // bus-busy flag: format select has priority over line events
        if (fmt_we)         r_d.busy = 1'b0;
        else if (start_det) r_d.busy = 1'b1;
        else if (stop_det)  r_d.busy = 1'b0;

        if (sdo_we && !srst) r_d.sdao = sdo_val;

        if (srst && is_tx)      r_d.tx_empty = 1'b1;
        else if (tx_wr && !srst) r_d.tx_empty = 1'b0;

        // own SDA drive delayed to line up with the synchronized sample
        r_d.sda_pipe = {r_q.sda_pipe[0], sda_drive};
        r_d.arb = ~gen_idle & ~r_q.sda_pipe[1] & ~r_q.sda_pipe[0] & scl_s & ~sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign scl_oe   = r_q.scl_low;
    assign sda_oe   = sda_drive;
    assign busy     = r_q.busy;
    assign tx_empty = r_q.tx_empty;
    assign arb_lost = r_q.arb;
    assign scl_mon  = srst | scl_s;
    assign sda_mon  = srst | sda_s;
endmodule

// File: rtl/i2c_bus_guard_chk.sv
module i2c_bus_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic fmt_we,
    input logic srst,
    input logic is_tx,
    input logic busy,
    input logic tx_empty,
    input logic start_det,
    input logic stop_det,
    input logic gen_idle
);
    a_r1_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !fmt_we) |=> busy);

    a_r2_stop_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !fmt_we) |=> !busy);

    a_r6_fmt_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_we |=> !busy);

    a_r7_srst_sets_tx_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (srst && is_tx) |=> tx_empty);

    a_r8_srst_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (srst && busy && !stop_det && !fmt_we) |=> busy);

    a_r9_srst_no_new_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (srst && gen_idle) |=> gen_idle);
endmodule

bind i2c_bus_guard i2c_bus_guard_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt_we    (fmt_we),
    .srst      (srst),
    .is_tx     (is_tx),
    .busy      (busy),
    .tx_empty  (tx_empty),
    .start_det (start_det),
    .stop_det  (stop_det),
    .gen_idle  (gen_idle)
);

// File: tb/i2c_bus_guard_tb.sv
`timescale 1ns/1ps
module i2c_bus_guard_tb_top;
    localparam int HOLD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_oe, sda_oe, busy, scl_mon, sda_mon, tx_empty, arb_lost;
    logic is_master = 1'b1, is_tx = 1'b1, rx_full = 1'b0;
    logic ctl_we = 1'b0, ctl_busy = 1'b0, ctl_cmd = 1'b0, fmt_we = 1'b0;
    logic srst = 1'b0, sdo_we = 1'b0, sdo_val = 1'b1, tx_wr = 1'b0;
    logic ext_scl_low = 1'b0, ext_sda_low = 1'b0;
    logic scl_line, sda_line;
    logic arb_seen = 1'b0;
    int   n_chk = 0, n_bad = 0;
    int   n;

    always #10 clk = ~clk;

    // wired-AND bus with pull-ups
    assign scl_line = ~(scl_oe | ext_scl_low);
    assign sda_line = ~(sda_oe | ext_sda_low);

    i2c_bus_guard #(.HOLD_CYC(HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .is_master(is_master), .is_tx(is_tx),
        .rx_full(rx_full), .ctl_we(ctl_we), .ctl_busy(ctl_busy), .ctl_cmd(ctl_cmd),
        .fmt_we(fmt_we), .srst(srst), .sdo_we(sdo_we), .sdo_val(sdo_val),
        .tx_wr(tx_wr), .busy(busy), .scl_mon(scl_mon), .sda_mon(sda_mon),
        .tx_empty(tx_empty), .arb_lost(arb_lost)
    );

    always @(negedge clk) if (arb_lost) arb_seen <= 1'b1;

    task automatic step(input int cnt);
        repeat (cnt) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cmd(input logic b, input logic c);
        ctl_busy = b; ctl_cmd = c; ctl_we = 1'b1;
        step(1);
        ctl_we = 1'b0;
    endtask

    // clocks until selected enable (0: scl_oe, 1: sda_oe) equals val
    task automatic count_until(input logic sel, input logic val, output int cnt);
        cnt = 0;
        while (((sel ? sda_oe : scl_oe) != val) && cnt < 100) begin
            step(1);
            cnt++;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(4);
        // R14 reset state
        chk("R14 busy", busy, 0);
        chk("R14 scl_oe", scl_oe, 0);
        chk("R14 sda_oe", sda_oe, 0);
        chk("R14 tx_empty", tx_empty, 1);
        chk("R14 arb_lost", arb_lost, 0);

        // R5 sweep of mode/inhibit combinations that must not start
        for (int k = 0; k < 8; k++) begin
            if (k == 6) continue;
            is_master = k[2]; is_tx = k[1];
            cmd(1'b1, k[0]);
            step(6);
            chk("R5 sda_oe", sda_oe, 0);
            chk("R5 busy", busy, 0);
        end
        is_master = 1'b1; is_tx = 1'b1;

        // R1 / R2 conditions driven on the pins
        ext_sda_low = 1'b1; step(4);
        chk("R1 busy", busy, 1);
        ext_sda_low = 1'b0; step(4);
        chk("R2 busy", busy, 0);

        // R13 software SDA bit
        sdo_val = 1'b0; sdo_we = 1'b1; step(1); sdo_we = 1'b0;
        chk("R13 sda_oe low", sda_oe, 1);
        step(4);
        chk("R1 busy via sdo", busy, 1);
        sdo_val = 1'b1; sdo_we = 1'b1; step(1); sdo_we = 1'b0;
        chk("R13 sda_oe release", sda_oe, 0);
        step(4);
        chk("R2 busy via sdo", busy, 0);

        // R7 transmit-empty and monitors
        tx_wr = 1'b1; step(1); tx_wr = 1'b0;
        chk("R7 tx_wr clears", tx_empty, 0);
        srst = 1'b1; step(1);
        chk("R7 srst sets tx_empty", tx_empty, 1);
        ext_scl_low = 1'b1; ext_sda_low = 1'b1; step(4);
        chk("R7 scl_mon", scl_mon, 1);
        chk("R7 sda_mon", sda_mon, 1);
        ext_sda_low = 1'b0; step(1);
        ext_scl_low = 1'b0; step(4);

        // R9 writes blocked during soft reset
        sdo_val = 1'b0; sdo_we = 1'b1; step(1); sdo_we = 1'b0; sdo_val = 1'b1;
        step(2);
        chk("R9 sdo blocked", sda_oe, 0);
        cmd(1'b1, 1'b0);
        step(6);
        chk("R9 start blocked sda", sda_oe, 0);
        chk("R9 start blocked scl", scl_oe, 0);
        srst = 1'b0;
        ext_scl_low = 1'b1; step(4);
        chk("R7 scl_mon after srst", scl_mon, 0);
        ext_scl_low = 1'b0; step(4);

        // R8 busy survives soft reset, STOP during it clears
        ext_sda_low = 1'b1; step(4);
        srst = 1'b1; step(5);
        chk("R8 busy kept", busy, 1);
        ext_sda_low = 1'b0; step(4);
        chk("R8 stop in srst", busy, 0);
        srst = 1'b0; step(2);

        // R6 format select clears busy
        ext_sda_low = 1'b1; step(4);
        chk("R6 busy set first", busy, 1);
        fmt_we = 1'b1; step(1); fmt_we = 1'b0;
        chk("R6 busy cleared", busy, 0);
        ext_sda_low = 1'b0; step(4);
        chk("R6 busy stays", busy, 0);

        // R3 generated START
        cmd(1'b1, 1'b0);
        chk("R3 sda_oe", sda_oe, 1);
        chk("R3 scl_oe not yet", scl_oe, 0);
        count_until(1'b0, 1'b1, n);
        chk("R3 hold clocks", n, HOLD);
        chk("R3 busy", busy, 1);

        // R4 generated STOP
        step(3);
        cmd(1'b0, 1'b0);
        chk("R4 scl released", scl_oe, 0);
        chk("R4 sda held", sda_oe, 1);
        count_until(1'b1, 1'b0, n);
        chk("R4 hold clocks", n, HOLD);
        step(4);
        chk("R4 busy", busy, 0);
        chk("R12 no false arb", arb_seen, 0);

        // R11 repeated START
        cmd(1'b1, 1'b0);
        count_until(1'b0, 1'b1, n);
        step(3);
        cmd(1'b1, 1'b0);
        chk("R11 sda released", sda_oe, 0);
        chk("R11 scl held", scl_oe, 1);
        count_until(1'b0, 1'b0, n);
        chk("R11 scl release gap", n, HOLD);
        count_until(1'b1, 1'b1, n);
        chk("R11 sda pull gap", n, HOLD);
        count_until(1'b0, 1'b1, n);
        chk("R11 scl pull gap", n, HOLD);
        chk("R11 busy", busy, 1);
        chk("R12 no arb in rs", arb_seen, 0);

        // R10 STOP parked in master receive
        step(3);
        is_tx = 1'b0;
        cmd(1'b0, 1'b0);
        step(10);
        chk("R10 stop held", scl_oe, 1);
        rx_full = 1'b1; step(1); rx_full = 1'b0;
        chk("R10 stop released", scl_oe, 0);
        step(HOLD + 4);
        chk("R10 sda released", sda_oe, 0);
        chk("R10 busy", busy, 0);
        is_tx = 1'b1;

        // R12 arbitration loss during repeated START
        cmd(1'b1, 1'b0);
        count_until(1'b0, 1'b1, n);
        step(3);
        cmd(1'b1, 1'b0);
        count_until(1'b0, 1'b0, n);
        ext_sda_low = 1'b1;
        step(HOLD + 1);
        chk("R12 arb seen", arb_seen, 1);
        ext_sda_low = 1'b0;
        step(4 * HOLD);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule